// File: doc/BRIEF.md
# SPI-Attached Ring Network Node

This block is one station on a small unidirectional packet ring. A local host reaches it through a SPI slave port. Each host transaction is a single 16-bit full-duplex exchange. The word the host shifts in may be a new outgoing packet. The word the node shifts back out is the packet currently waiting for the host, or a word with no valid flag when nothing is waiting.

A packet is 16 bits wide:
- bit 15 is the valid flag;
- bit 14 is reserved and travels unchanged;
- bits 13:11 are the destination address;
- bits 10:8 are the source address;
- bits 7:0 are the payload.

The node holds one receive slot and one transmit slot. Packets on the ring input that are addressed to the node's own 3-bit address go to the receive slot. Every other ring packet is passed to the ring output, and these forwarded packets take precedence over host packets waiting to be injected.

The serial lines are sampled by the system clock through two-flop synchronizers. Edges are found in that clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `ringnet_node`

## Requirements
- R1: After reset, rx_ready is 0, tx_free is 1, ring_out_valid is 0, and a host read returns 16'h0000.
- R2: A frame is framed by spi_cs_n low and carries 16 bits, MSB first. MOSI is captured on the rising edge of spi_sck and MISO changes after the falling edge. A complete frame whose bit 15 is 1 enters the transmit slot and leaves on ring_out_data bit-for-bit unchanged, including reserved bit 14.
- R3: A complete frame whose bit 15 is 0 is never injected: ring_out sees no new packet and tx_free stays 1.
- R4: A ring packet whose bits 13:11 equal node_id is accepted into an empty receive slot. It raises rx_ready and is not forwarded.
- R5: A ring packet whose bits 13:11 differ from node_id, including codes 6 and 7, is forwarded unchanged on ring_out.
- R6: During a frame, MISO carries the waiting packet MSB first while the host's word is shifted in. rx_ready falls after spi_cs_n rises at the end of a complete 16-bit frame.
- R7: A frame started while no packet waits returns 16'h0000, so bit 15 is 0.
- R8: A frame ended after fewer than 16 bits is discarded. It injects nothing and leaves rx_ready set.
- R9: While the receive slot is full, ring_in_ready stays low for a packet addressed to this node. That packet is accepted once the host has read the slot.
- R10: tx_free is 0 while the transmit slot holds a packet. A valid frame that completes while tx_free is 0 is dropped.
- R11: When the output register frees up, a forwarded ring packet takes it before a waiting host packet.
- R12: While ring_out_valid is 1 and ring_out_ready is 0, ring_out_valid and ring_out_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 3 | This node's ring address |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rx_ready | output | 1 | A delivered packet waits for the host |
| tx_free | output | 1 | Transmit slot can take a packet |
| ring_in_valid | input | 1 | Upstream packet present |
| ring_in_data | input | 16 | Upstream packet |
| ring_in_ready | output | 1 | Node takes the upstream packet |
| ring_out_valid | output | 1 | Downstream packet present |
| ring_out_data | output | 16 | Downstream packet |
| ring_out_ready | input | 1 | Downstream takes the packet |

## Verification
The bench builds the node with its default parameters: 16-bit packets, 3-bit addresses and two synchronizer stages. The node address is a port, so one build covers every address. It sweeps all six node addresses against every destination code 0 to 7, including the two unused codes. This tests both host injection and ring delivery or forwarding for each pairing. Holding ring_out_ready low stacks up the output register and the transmit slot, which exercises the drop, precedence and hold behaviour.

// File: rtl/ringnet_pkg.sv
package ringnet_pkg;
  localparam int PKT_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int VALID_B  = PKT_W - 1;
  localparam int DST_LO   = 11;
  localparam int SRC_LO   = 8;
  localparam int SYNC_N   = 2;

  typedef logic [PKT_W-1:0]  pkt_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic logic pkt_is_valid(input pkt_t p);
    return p[VALID_B];
  endfunction

  function automatic addr_t pkt_dest(input pkt_t p);
    return p[DST_LO +: ADDR_W];
  endfunction

  function automatic logic pkt_for_me(input pkt_t p, input addr_t me);
    return pkt_dest(p) == me;
  endfunction
endpackage

// File: rtl/ringnet_sync.sv
module ringnet_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ringnet_spi_port.sv
module ringnet_spi_port
  import ringnet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic mosi_s,
  input  pkt_t rd_word,
  input  logic rd_avail,
  output logic miso,
  output logic frame_done,
  output logic frame_read,
  output pkt_t frame_word
);
  localparam int                CNT_W    = $clog2(PKT_W + 2);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(PKT_W);
  localparam logic [CNT_W-1:0]  OVER_CNT = CNT_W'(PKT_W + 1);

  logic             sck_q, cs_q, loaded;
  logic [CNT_W-1:0] bit_cnt;
  pkt_t             in_sh, out_sh;
  logic             active, sck_rise, sck_fall, cs_start, cs_end;

  assign active   = ~cs_n_s;
  assign sck_rise = active & sck_s & ~sck_q;
  assign sck_fall = active & ~sck_s & sck_q;
  assign cs_start = ~cs_n_s & cs_q;
  assign cs_end   = cs_n_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      loaded  <= 1'b0;
      bit_cnt <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cs_start) begin
        bit_cnt <= '0;
        out_sh  <= rd_word;
        loaded  <= rd_avail;
      end else begin
        if (sck_rise) begin
          in_sh <= {in_sh[PKT_W-2:0], mosi_s};
          if (bit_cnt != OVER_CNT) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) out_sh <= {out_sh[PKT_W-2:0], 1'b0};
      end
    end
  end

  assign miso       = out_sh[PKT_W-1];
  assign frame_done = cs_end && (bit_cnt == FULL_CNT);
  assign frame_read = frame_done && loaded;
  assign frame_word = in_sh;
endmodule

// File: rtl/ringnet_router.sv
module ringnet_router
  import ringnet_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t node_id,
  input  logic  in_valid,
  input  pkt_t  in_data,
  output logic  in_ready,
  output logic  out_valid,
  output pkt_t  out_data,
  input  logic  out_ready,
  input  logic  host_valid,
  input  pkt_t  host_word,
  input  logic  rx_clear,
  output logic  rx_full,
  output pkt_t  rx_word,
  output logic  tx_full,
  output logic  ev_deliver,
  output logic  ev_forward,
  output logic  ev_inject
);
  pkt_t tx_word;
  logic mine, slot_free, tx_load;

  assign mine       = in_valid && pkt_for_me(in_data, node_id);
  assign slot_free  = ~out_valid | out_ready;
  assign ev_deliver = mine && !rx_full;
  assign ev_forward = in_valid && !mine && slot_free;
  assign ev_inject  = tx_full && slot_free && !ev_forward;
  assign in_ready   = mine ? !rx_full : slot_free;
  assign tx_load    = host_valid && !tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      tx_full   <= 1'b0;
      tx_word   <= '0;
      rx_full   <= 1'b0;
      rx_word   <= '0;
    end else begin
      if (ev_forward) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (ev_inject) begin
        out_valid <= 1'b1;
        out_data  <= tx_word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end

      if (tx_load) begin
        tx_full <= 1'b1;
        tx_word <= host_word;
      end else if (ev_inject) begin
        tx_full <= 1'b0;
      end

      if (ev_deliver) begin
        rx_full <= 1'b1;
        rx_word <= in_data;
      end else if (rx_clear) begin
        rx_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ringnet_node.sv
module ringnet_node
  import ringnet_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  node_id,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        rx_ready,
  output logic        tx_free,
  input  logic        ring_in_valid,
  input  logic [15:0] ring_in_data,
  output logic        ring_in_ready,
  output logic        ring_out_valid,
  output logic [15:0] ring_out_data,
  input  logic        ring_out_ready
);
  logic [2:0] sync_q;
  logic       sck_s, cs_n_s, mosi_s;
  logic       frame_done, frame_read, host_valid;
  pkt_t       frame_word, rd_word, rx_word;
  logic       rx_full, tx_full;
  logic       ev_deliver, ev_forward, ev_inject;

  ringnet_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sck, spi_cs_n, spi_mosi}),
    .q    (sync_q)
  );
  assign {sck_s, cs_n_s, mosi_s} = sync_q;

  assign rd_word = rx_full ? rx_word : '0;

  ringnet_spi_port u_spi (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s),
    .rd_word   (rd_word),
    .rd_avail  (rx_full),
    .miso      (spi_miso),
    .frame_done(frame_done),
    .frame_read(frame_read),
    .frame_word(frame_word)
  );

  assign host_valid = frame_done && pkt_is_valid(frame_word);

  ringnet_router u_rtr (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_id   (node_id),
    .in_valid  (ring_in_valid),
    .in_data   (ring_in_data),
    .in_ready  (ring_in_ready),
    .out_valid (ring_out_valid),
    .out_data  (ring_out_data),
    .out_ready (ring_out_ready),
    .host_valid(host_valid),
    .host_word (frame_word),
    .rx_clear  (frame_read),
    .rx_full   (rx_full),
    .rx_word   (rx_word),
    .tx_full   (tx_full),
    .ev_deliver(ev_deliver),
    .ev_forward(ev_forward),
    .ev_inject (ev_inject)
  );

  assign rx_ready = rx_full;
  assign tx_free  = ~tx_full;
endmodule

// File: rtl/ringnet_node_chk.sv
module ringnet_node_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  node_id,
  input logic        ring_in_valid,
  input logic [15:0] ring_in_data,
  input logic        ring_in_ready,
  input logic        ring_out_valid,
  input logic [15:0] ring_out_data,
  input logic        ring_out_ready,
  input logic        rx_ready,
  input logic        tx_free,
  input logic        frame_done,
  input logic [15:0] frame_word
);
  logic for_me;
  assign for_me = ring_in_data[13:11] == node_id;

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid && !ring_out_ready |=> ring_out_valid && $stable(ring_out_data));

  assert_out_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid |-> ring_out_data[15]);

  assert_invalid_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_word[15] && tx_free |=> tx_free);

  assert_rx_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(ring_in_valid && ring_in_ready && for_me));

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && for_me && rx_ready |-> !ring_in_ready);

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(frame_done));

  assert_ring_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && !for_me && (!ring_out_valid || ring_out_ready) |-> ring_in_ready);
endmodule

bind ringnet_node ringnet_node_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .node_id       (node_id),
  .ring_in_valid (ring_in_valid),
  .ring_in_data  (ring_in_data),
  .ring_in_ready (ring_in_ready),
  .ring_out_valid(ring_out_valid),
  .ring_out_data (ring_out_data),
  .ring_out_ready(ring_out_ready),
  .rx_ready      (rx_ready),
  .tx_free       (tx_free),
  .frame_done    (frame_done),
  .frame_word    (frame_word)
);

// File: tb/ringnet_node_tb.sv
`timescale 1ns/1ps
module ringnet_node_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  node_id = 3'd0;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, rx_ready, tx_free;
  logic        ring_in_valid = 1'b0;
  logic [15:0] ring_in_data = '0;
  logic        ring_in_ready, ring_out_valid;
  logic [15:0] ring_out_data;
  logic        ring_out_ready = 1'b1;

  int n_chk = 0, n_fail = 0, out_cnt = 0;
  logic [15:0] log_q [256];

  always #5 clk = ~clk;

  ringnet_node u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rx_ready(rx_ready), .tx_free(tx_free),
    .ring_in_valid(ring_in_valid), .ring_in_data(ring_in_data), .ring_in_ready(ring_in_ready),
    .ring_out_valid(ring_out_valid), .ring_out_data(ring_out_data), .ring_out_ready(ring_out_ready)
  );

  always @(negedge clk) begin
    if (ring_out_valid && ring_out_ready) begin
      log_q[out_cnt[7:0]] <= ring_out_data;
      out_cnt <= out_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic r, input int d, input int s, input logic [7:0] p);
    return {1'b1, r, d[2:0], s[2:0], p};
  endfunction

  task automatic spi_xfer(input logic [15:0] w, input int nbits, output logic [15:0] rd);
    rd = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = w[15-i];
      #40 spi_sck = 1'b1;
      #20 rd[15-i] = spi_miso;
      #20 spi_sck = 1'b0;
    end
    #40 spi_cs_n = 1'b1;
    #100;
  endtask

  task automatic ring_send(input logic [15:0] w);
    @(negedge clk);
    ring_in_valid = 1'b1;
    ring_in_data  = w;
    for (int g = 0; g < 2000 && !ring_in_ready; g++) @(negedge clk);
    @(negedge clk);
    ring_in_valid = 1'b0;
  endtask

  initial begin : wdog
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] rd, p, q, a, b, c, f;
    int base;
    #35 rst_n = 1'b1;
    #20;
    // R1 reset state
    check("R1 rx_ready", {15'd0, rx_ready}, 16'h0);
    check("R1 tx_free", {15'd0, tx_free}, 16'h1);
    check("R1 ring_out_valid", {15'd0, ring_out_valid}, 16'h0);
    spi_xfer(16'h0000, 16, rd);
    check("R1 empty read", rd, 16'h0000);

    // R2/R3/R7 host injection sweep over every node and destination
    for (int me = 0; me < 6; me++) begin
      node_id = me[2:0];
      for (int d = 0; d < 8; d++) begin
        p = mk(d[0], d, me, 8'(8'h3c ^ (me * 8 + d)));
        base = out_cnt;
        spi_xfer(p, 16, rd);
        check("R7 no waiting packet", rd, 16'h0000);
        check("R2 one packet out", 16'(out_cnt - base), 16'd1);
        check("R2 packet unchanged", log_q[base[7:0]], p);
      end
      base = out_cnt;
      spi_xfer(16'h7fff, 16, rd);
      check("R3 invalid not injected", 16'(out_cnt - base), 16'd0);
      check("R3 tx_free kept", {15'd0, tx_free}, 16'h1);
    end

    // R4/R5/R6 ring delivery and forwarding sweep
    for (int me = 0; me < 6; me++) begin
      node_id = me[2:0];
      for (int d = 0; d < 8; d++) begin
        p = mk(~d[0], d, (me + 1) % 6, 8'(8'ha5 + me * 8 + d));
        base = out_cnt;
        ring_send(p);
        #60;
        if (d == me) begin
          check("R4 rx_ready set", {15'd0, rx_ready}, 16'h1);
          check("R4 not forwarded", 16'(out_cnt - base), 16'd0);
          spi_xfer(16'h0000, 16, rd);
          check("R6 read returns packet", rd, p);
          check("R6 rx_ready cleared", {15'd0, rx_ready}, 16'h0);
        end else begin
          check("R5 forwarded count", 16'(out_cnt - base), 16'd1);
          check("R5 forwarded data", log_q[base[7:0]], p);
          check("R5 rx_ready low", {15'd0, rx_ready}, 16'h0);
        end
      end
    end

    // R8 short frame, then R6 full duplex read while sending
    node_id = 3'd2;
    p = mk(1'b0, 2, 4, 8'h11);
    ring_send(p);
    #60;
    q = mk(1'b1, 5, 2, 8'h77);
    base = out_cnt;
    spi_xfer(q, 10, rd);
    check("R8 short frame no inject", 16'(out_cnt - base), 16'd0);
    check("R8 short frame rx kept", {15'd0, rx_ready}, 16'h1);
    spi_xfer(q, 16, rd);
    check("R6 duplex read", rd, p);
    check("R6 duplex rx cleared", {15'd0, rx_ready}, 16'h0);
    check("R2 duplex inject", log_q[base[7:0]], q);

    // R9 full receive slot blocks a second packet for this node
    p = mk(1'b0, 2, 1, 8'h21);
    q = mk(1'b0, 2, 3, 8'h22);
    ring_send(p);
    #60;
    @(negedge clk);
    ring_in_valid = 1'b1;
    ring_in_data  = q;
    #50;
    check("R9 ready low while full", {15'd0, ring_in_ready}, 16'h0);
    spi_xfer(16'h0000, 16, rd);
    check("R9 first packet read", rd, p);
    check("R9 second delivered", {15'd0, rx_ready}, 16'h1);
    ring_in_valid = 1'b0;
    spi_xfer(16'h0000, 16, rd);
    check("R9 second packet read", rd, q);

    // R10/R12 transmit slot full, drop, hold
    base = out_cnt;
    a = mk(1'b0, 0, 2, 8'ha1);
    b = mk(1'b1, 1, 2, 8'hb2);
    c = mk(1'b0, 3, 2, 8'hc3);
    ring_out_ready = 1'b0;
    spi_xfer(a, 16, rd);
    check("R12 held valid", {15'd0, ring_out_valid}, 16'h1);
    check("R12 held data", ring_out_data, a);
    spi_xfer(b, 16, rd);
    check("R10 tx_free low", {15'd0, tx_free}, 16'h0);
    spi_xfer(c, 16, rd);
    check("R12 still held", ring_out_data, a);
    @(negedge clk);
    ring_out_ready = 1'b1;
    #200;
    check("R10 two leave", 16'(out_cnt - base), 16'd2);
    check("R10 order a", log_q[base[7:0]], a);
    check("R10 c dropped, b sent", log_q[8'(base + 1)], b);
    check("R10 tx_free back", {15'd0, tx_free}, 16'h1);

    // R11 ring packet beats waiting host packet
    base = out_cnt;
    f = mk(1'b0, 7, 4, 8'hf0);
    ring_out_ready = 1'b0;
    spi_xfer(a, 16, rd);
    spi_xfer(b, 16, rd);
    @(negedge clk);
    ring_in_valid  = 1'b1;
    ring_in_data   = f;
    ring_out_ready = 1'b1;
    @(negedge clk);
    ring_in_valid  = 1'b0;
    #200;
    check("R11 three leave", 16'(out_cnt - base), 16'd3);
    check("R11 first a", log_q[base[7:0]], a);
    check("R11 ring first", log_q[8'(base + 1)], f);
    check("R11 host after", log_q[8'(base + 2)], b);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule